// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates among thirteen level-sensitive interrupt sources, numbered 1 to 13, and presents the processor with one interrupt level (3 bits) and one vector number (8 bits). Each source has an 8-bit control register. The low five bits of that register form a rank: the upper three bits of the rank are the interrupt level and the lower two bits order sources within a level. A mask register blocks individual sources. The source inputs are sampled every clock into a read-only pending register.

Among the sources that are pending and not masked, the one with the largest rank wins. A rank below 4 means level 0, and nothing is signalled. Bit 7 of the winner's control register picks the vector. When it is set, the vector is an autovector derived from the level. When it is clear, the vector comes from one of three programmable vector registers tied to particular sources, or from a fixed default for any other source. Software programs and inspects all state through a byte-wide register bus with a combinational read path.

Top module: `pvic_top`

## Requirements
- R1: After reset, control registers for sources 1..13 read 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00, 0x00. The mask reads 0x3FFE, the reset-status register reads 0x80, the watchdog vector register reads 0x0F, and irq_level and irq_vector are 0.
- R2: Pending bit n equals irq_src[n] from the previous clock. The 16-bit pending word has bit n for source n, with bits 0, 14 and 15 reading 0. Its high byte is at 0x3A and its low byte at 0x3B, and writes to these addresses are ignored.
- R3: A source takes part in arbitration only when its pending bit is 1 and its mask bit (bit n of the mask word) is 0. A masked source never produces an interrupt.
- R4: The winner is the participating source with the largest control bits 4:0. On equal values, the lower-numbered source wins. irq_level is bits 4:2 of the winner's control register.
- R5: When no source takes part, or the winning value is below 4, irq_level and irq_vector are both 0.
- R6: When bit 7 of the winner's control register is 1, irq_vector is 24 + irq_level.
- R7: When bit 7 of the winner's control register is 0, the vector depends on the source. Source 8 takes the watchdog vector register at 0x42. Source 12 takes the first serial vector register at 0x44. Source 13 takes the second serial vector register at 0x45. Any other source gives 0x0F.
- R8: The reset-status register at 0x40 is write-one-to-clear: each written 1 clears that bit, and written 0s leave bits unchanged.
- R9: Source n's control register is at byte 0x13+n. The mask's high byte is at 0x36 and its low byte at 0x37. Both serial vector registers reset to 0x0F. Reads of unmapped addresses return 0.
- R10: irq_level and irq_vector are registered. They reflect pending, mask, control and vector state one clock after that state changes, so a source input change appears on the outputs two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 13 | Level-sensitive source requests, bit n = source n |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| irq_level | output | 3 | Registered interrupt level, 0 = none |
| irq_vector | output | 8 | Registered vector number |

## Verification
Assertions check several properties on every cycle. The pending register tracks the inputs with one clock of delay. The reset-status register only ever loses bits, and it loses every bit written as 1. The arbiter's choice is active, and no active source outranks it or ties with it at a lower number. A level-0 output always carries vector 0. The vector source follows the autovector bit and the source number.

Other behaviours can only be shown by the bench's scenarios. These include the exact reset contents of the register map, the address decoding, the fact that writes to the pending bytes are ignored, and the full two-clock path from a source edge to the outputs. For these, a behavioural model is compared against the outputs on every clock.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam logic [7:0] CTRL_BASE = 8'h13;
  localparam logic [7:0] MASK_HI   = 8'h36;
  localparam logic [7:0] MASK_LO   = 8'h37;
  localparam logic [7:0] PEND_HI   = 8'h3A;
  localparam logic [7:0] PEND_LO   = 8'h3B;
  localparam logic [7:0] STAT_ADDR = 8'h40;
  localparam logic [7:0] WDV_ADDR  = 8'h42;
  localparam logic [7:0] UV0_ADDR  = 8'h44;
  localparam logic [7:0] UV1_ADDR  = 8'h45;

  localparam logic [15:0] MASK_RST  = 16'h3FFE;
  localparam logic [7:0]  STAT_RST  = 8'h80;
  localparam logic [7:0]  VEC_RST   = 8'h0F;
  localparam logic [7:0]  UNSET_VEC = 8'h0F;
  localparam logic [7:0]  AUTO_BASE = 8'd24;
  localparam logic [4:0]  RANK_FLOOR = 5'd4;

  // key = {autovector select, rank[4:0]}
  function automatic logic [4:0] rank_of(input logic [5:0] key);
    return key[4:0];
  endfunction

  function automatic logic [2:0] level_of(input logic [4:0] rank);
    return rank[4:2];
  endfunction

  function automatic logic [7:0] autovec(input logic [2:0] lvl);
    return AUTO_BASE + {5'd0, lvl};
  endfunction

  // Reset value of control register for source n
  function automatic logic [7:0] ctrl_reset(input int n);
    if (n >= 1 && n <= 7) return 8'(n * 4);
    if (n == 8)           return 8'h1C;
    if (n >= 9 && n <= 11) return 8'h80;
    return 8'h00;
  endfunction
endpackage

// File: rtl/pvic_regs.sv
module pvic_regs
  import pvic_pkg::*;
#(
  parameter int NSRC = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC:1]        src_in,
  input  logic                 bus_we,
  input  logic [7:0]           bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic [NSRC:1]        pend_q,
  output logic [NSRC:1]        mask_src,
  output logic [NSRC:1][5:0]   key,
  output logic [7:0]           wdv_q,
  output logic [7:0]           uv0_q,
  output logic [7:0]           uv1_q
);
  logic [NSRC:1][7:0] ctrl_q;
  logic [15:0]        mask_q;
  logic [7:0]         stat_q;
  logic [15:0]        pend_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= src_in;
  end

  for (genvar n = 1; n <= NSRC; n++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctrl_q[n] <= ctrl_reset(n);
      else if (bus_we && bus_addr == CTRL_BASE + 8'(n))
        ctrl_q[n] <= bus_wdata;
    end
    assign key[n] = {ctrl_q[n][7], ctrl_q[n][4:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      stat_q <= STAT_RST;
      wdv_q  <= VEC_RST;
      uv0_q  <= VEC_RST;
      uv1_q  <= VEC_RST;
    end else if (bus_we) begin
      case (bus_addr)
        MASK_HI:   mask_q[15:8] <= bus_wdata;
        MASK_LO:   mask_q[7:0]  <= bus_wdata;
        STAT_ADDR: stat_q       <= stat_q & ~bus_wdata;
        WDV_ADDR:  wdv_q        <= bus_wdata;
        UV0_ADDR:  uv0_q        <= bus_wdata;
        UV1_ADDR:  uv1_q        <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign mask_src = mask_q[NSRC:1];

  always_comb begin
    pend_word = '0;
    pend_word[NSRC:1] = pend_q;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      MASK_HI:   bus_rdata = mask_q[15:8];
      MASK_LO:   bus_rdata = mask_q[7:0];
      PEND_HI:   bus_rdata = pend_word[15:8];
      PEND_LO:   bus_rdata = pend_word[7:0];
      STAT_ADDR: bus_rdata = stat_q;
      WDV_ADDR:  bus_rdata = wdv_q;
      UV0_ADDR:  bus_rdata = uv0_q;
      UV1_ADDR:  bus_rdata = uv1_q;
      default: ;
    endcase
    for (int n = 1; n <= NSRC; n++)
      if (bus_addr == CTRL_BASE + 8'(n)) bus_rdata = ctrl_q[n];
  end

  AST_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend_q == $past(src_in)); // R2
  AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == STAT_ADDR) |=> (stat_q & $past(bus_wdata)) == 8'h00); // R8
  AST_STAT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q & ~$past(stat_q)) == 8'h00); // R8
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
  import pvic_pkg::*;
#(
  parameter int NSRC = 13,
  localparam int IW = $clog2(NSRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC:1]      pend,
  input  logic [NSRC:1]      mask,
  input  logic [NSRC:1][5:0] key,
  output logic               win_valid,
  output logic [IW-1:0]      win_idx,
  output logic [2:0]         win_level,
  output logic               win_auto
);
  logic [NSRC:1] active;
  logic [4:0]    win_rank;
  logic          found;
  logic [NSRC:1] beaten;

  assign active = pend & ~mask;

  // Strict greater-than keeps the lower-numbered source on a tie.
  always_comb begin
    found    = 1'b0;
    win_rank = '0;
    win_idx  = '0;
    win_auto = 1'b0;
    for (int n = 1; n <= NSRC; n++) begin
      if (active[n] && (!found || rank_of(key[n]) > win_rank)) begin
        found    = 1'b1;
        win_rank = rank_of(key[n]);
        win_idx  = IW'(n);
        win_auto = key[n][5];
      end
    end
    win_valid = found && (win_rank >= RANK_FLOOR);
    win_level = level_of(win_rank);
  end

  // A source beats the declared winner if it outranks it or ties at a lower number.
  for (genvar j = 1; j <= NSRC; j++) begin : g_beat
    assign beaten[j] = active[j] && win_valid &&
                       ((key[j][4:0] > win_rank) ||
                        (key[j][4:0] == win_rank && IW'(j) < win_idx));
  end

  AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> active[win_idx]); // R3
  AST_NONE_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    beaten == '0); // R4
endmodule

// File: rtl/pvic_vector.sv
module pvic_vector
  import pvic_pkg::*;
#(
  parameter int NSRC      = 13,
  parameter int WDT_SRC   = 8,
  parameter int UART0_SRC = 12,
  parameter int UART1_SRC = 13,
  localparam int IW = $clog2(NSRC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_valid,
  input  logic [IW-1:0] win_idx,
  input  logic [2:0]    win_level,
  input  logic          win_auto,
  input  logic [7:0]    wdv,
  input  logic [7:0]    uv0,
  input  logic [7:0]    uv1,
  output logic [2:0]    irq_level,
  output logic [7:0]    irq_vector
);
  logic [2:0] nxt_level;
  logic [7:0] nxt_vector;

  always_comb begin
    nxt_level  = '0;
    nxt_vector = '0;
    if (win_valid) begin
      nxt_level = win_level;
      if (win_auto)                     nxt_vector = autovec(win_level);
      else if (win_idx == IW'(WDT_SRC))   nxt_vector = wdv;
      else if (win_idx == IW'(UART0_SRC)) nxt_vector = uv0;
      else if (win_idx == IW'(UART1_SRC)) nxt_vector = uv1;
      else                              nxt_vector = UNSET_VEC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level  <= '0;
      irq_vector <= '0;
    end else begin
      irq_level  <= nxt_level;
      irq_vector <= nxt_vector;
    end
  end

  AST_QUIET_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == 3'd0 |-> irq_vector == 8'd0); // R5
  AST_AUTOVECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_auto) |=> irq_vector == AUTO_BASE + {5'd0, irq_level}); // R6
  AST_WDT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_auto && win_idx == IW'(WDT_SRC)) |=> irq_vector == $past(wdv)); // R7
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int NSRC      = 13,
  parameter int WDT_SRC   = 8,
  parameter int UART0_SRC = 12,
  parameter int UART1_SRC = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC:1]   irq_src,
  input  logic            bus_we,
  input  logic [7:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  output logic [2:0]      irq_level,
  output logic [7:0]      irq_vector
);
  localparam int IW = $clog2(NSRC + 1);

  logic [NSRC:1]      pend_q;
  logic [NSRC:1]      mask_src;
  logic [NSRC:1][5:0] key;
  logic [7:0]         wdv_q, uv0_q, uv1_q;
  logic               win_valid, win_auto;
  logic [IW-1:0]      win_idx;
  logic [2:0]         win_level;

  pvic_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_in(irq_src),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_q(pend_q), .mask_src(mask_src), .key(key),
    .wdv_q(wdv_q), .uv0_q(uv0_q), .uv1_q(uv1_q)
  );

  pvic_arbiter #(.NSRC(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend_q), .mask(mask_src), .key(key),
    .win_valid(win_valid), .win_idx(win_idx), .win_level(win_level), .win_auto(win_auto)
  );

  pvic_vector #(.NSRC(NSRC), .WDT_SRC(WDT_SRC), .UART0_SRC(UART0_SRC),
                .UART1_SRC(UART1_SRC)) u_vec (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_idx(win_idx),
    .win_level(win_level), .win_auto(win_auto),
    .wdv(wdv_q), .uv0(uv0_q), .uv1(uv1_q),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~mask_src) == '0) |=> irq_level == 3'd0); // R3
endmodule

// File: tb/pvic_top_tb.sv
module pvic_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:1] src = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;

  always #4 clk = ~clk;

  pvic_top u_dut (
    .clk(clk), .rst_n(rst_n), .irq_src(src), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_level(irq_level), .irq_vector(irq_vector)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  bit running = 1'b0;
  string cur_tag = "R1";

  // Behavioural model
  int m_ctrl [1:13];
  int m_mask, m_pend, m_stat, m_wdv, m_uv0, m_uv1;
  int e_lvl, e_vec, bv, bn;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 1; n <= 13; n++)
        m_ctrl[n] = (n <= 7) ? 4 * n : (n == 8) ? 'h1C : (n <= 11) ? 'h80 : 0;
      m_mask = 'h3FFE; m_pend = 0; m_stat = 'h80;
      m_wdv = 'h0F; m_uv0 = 'h0F; m_uv1 = 'h0F;
      e_lvl = 0; e_vec = 0;
    end else begin
      bv = -1; bn = 0;
      for (int n = 1; n <= 13; n++)
        if ((((m_pend >> n) & 1) == 1) && (((m_mask >> n) & 1) == 0) && (m_ctrl[n] % 32) > bv) begin
          bv = m_ctrl[n] % 32; bn = n;
        end
      if (bn == 0 || bv < 4) begin
        e_lvl = 0; e_vec = 0;
      end else begin
        e_lvl = bv / 4;
        if (m_ctrl[bn] >= 128) e_vec = 24 + e_lvl;
        else if (bn == 8)      e_vec = m_wdv;
        else if (bn == 12)     e_vec = m_uv0;
        else if (bn == 13)     e_vec = m_uv1;
        else                   e_vec = 15;
      end
      m_pend = int'(src) * 2;
      if (bus_we) begin
        if (bus_addr >= 8'h14 && bus_addr <= 8'h20) m_ctrl[int'(bus_addr) - 'h13] = int'(bus_wdata);
        case (bus_addr)
          8'h36: m_mask = (m_mask & 'hFF) | (int'(bus_wdata) * 256);
          8'h37: m_mask = (m_mask & 'hFF00) | int'(bus_wdata);
          8'h40: m_stat = m_stat & ~int'(bus_wdata);
          8'h42: m_wdv = int'(bus_wdata);
          8'h44: m_uv0 = int'(bus_wdata);
          8'h45: m_uv1 = int'(bus_wdata);
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison against the model (R10 latency and all selection rules)
  always @(negedge clk) begin
    if (rst_n && running) begin
      compared++;
      if (int'(irq_level) != e_lvl || int'(irq_vector) != e_vec) begin
        mismatched++;
        $display("FAIL %s/R10 cycle compare: level=%0d vector=%0h expected level=%0d vector=%0h",
                 cur_tag, irq_level, irq_vector, e_lvl, e_vec);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input int exp);
    bus_addr = a;
    #1;
    chk(tag, int'(bus_rdata), exp);
  endtask

  task automatic set_src(input logic [13:1] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic out_chk(input string tag, input int lvl, input int vec);
    chk({tag, " level"}, int'(irq_level), lvl);
    chk({tag, " vector"}, int'(irq_vector), vec);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
    // R1: reset contents
    cur_tag = "R1";
    for (int n = 1; n <= 13; n++)
      rd_chk("R1 ctrl", 8'(8'h13 + n), (n <= 7) ? 4 * n : (n == 8) ? 'h1C : (n <= 11) ? 'h80 : 0);
    rd_chk("R1 mask hi", 8'h36, 'h3F);
    rd_chk("R1 mask lo", 8'h37, 'hFE);
    rd_chk("R1 status", 8'h40, 'h80);
    rd_chk("R1 wdt vec", 8'h42, 'h0F);
    rd_chk("R9 uart vec reset", 8'h44, 'h0F);
    out_chk("R1 outputs", 0, 0);

    // R2: pending tracks sources, writes ignored
    cur_tag = "R2";
    set_src(13'h0A5);
    rd_chk("R2 pend hi", 8'h3A, 'h01);
    rd_chk("R2 pend lo", 8'h3B, 'h4A);
    wr(8'h3A, 8'hFF);
    wr(8'h3B, 8'h00);
    rd_chk("R2 pend hi after write", 8'h3A, 'h01);
    rd_chk("R2 pend lo after write", 8'h3B, 'h4A);
    out_chk("R3 all masked", 0, 0);

    // R10 / R3: unmask source 3, latency of one clock after mask change
    cur_tag = "R3";
    set_src(13'h004);
    wr(8'h36, 8'h00);
    wr(8'h37, 8'h00);
    out_chk("R10 before update", 0, 0);
    @(negedge clk);
    out_chk("R10 after update", 3, 'h0F);
    wr(8'h37, 8'h08);
    @(negedge clk);
    out_chk("R3 masked source", 0, 0);
    wr(8'h37, 8'h00);

    // R4: ties and ranking
    cur_tag = "R4";
    set_src(13'h0C0);
    out_chk("R4 tie lower wins", 7, 'h0F);
    wr(8'h42, 8'h55);
    cur_tag = "R7";
    set_src(13'h080);
    out_chk("R7 watchdog vector", 7, 'h55);
    cur_tag = "R4";
    set_src(13'h021);
    out_chk("R4 larger rank wins", 6, 'h0F);

    // R5: floor
    cur_tag = "R5";
    wr(8'h18, 8'h03);
    set_src(13'h010);
    out_chk("R5 below floor", 0, 0);

    // R6: autovector
    cur_tag = "R6";
    wr(8'h1C, 8'h95);
    set_src(13'h100);
    out_chk("R6 autovector", 5, 29);

    // R7: programmed vectors
    cur_tag = "R7";
    wr(8'h1F, 8'h18);
    wr(8'h20, 8'h19);
    wr(8'h44, 8'h61);
    wr(8'h45, 8'h62);
    set_src(13'h1800);
    out_chk("R7 second serial (R4 priority bits)", 6, 'h62);
    set_src(13'h0800);
    out_chk("R7 first serial", 6, 'h61);
    set_src(13'h002);
    out_chk("R7 default vector", 2, 'h0F);

    // R8: write-one-to-clear status
    cur_tag = "R8";
    wr(8'h40, 8'h7F);
    rd_chk("R8 zeros keep", 8'h40, 'h80);
    wr(8'h40, 8'h80);
    rd_chk("R8 ones clear", 8'h40, 'h00);

    // R9: address map
    cur_tag = "R9";
    rd_chk("R9 unmapped", 8'h10, 0);
    rd_chk("R9 ctrl 9", 8'h1C, 'h95);
    rd_chk("R9 mask lo", 8'h37, 'h00);
    rd_chk("R9 serial vec 2", 8'h45, 'h62);

    set_src(13'h000);
    out_chk("R5 idle", 0, 0);
    running = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule